// File: doc/BRIEF.md
# Packed Lane Saturate and Widen Unit

This block is the pack/unpack stage of a DSP arithmetic unit. In pack mode it reads a register pair, the low register and the high register, as four signed 16-bit lanes. It saturates each lane to a signed byte and places the four bytes in one 32-bit word. In unpack mode it splits one 32-bit word into four signed bytes. It widens each byte to 16 bits and spreads the results across two 32-bit output words.

Two scalar modes widen the low byte or the low halfword of the low register to a full signed word. A per-lane saturation vector marks every lane that pack had to clamp. Results appear one clock after the operands and the mode are presented. No other work is done.

Top module: `simd_pack_unit`

## Requirements
- R1: While `rst_n` is low, `res_lo`, `res_hi` and `sat_flags` are all zero.
- R2: Every output is registered. It takes the value computed from the inputs sampled at a rising clock edge and holds that value until the next edge.
- R3: `op_sel` encoding: 2'b00 pack, 2'b01 unpack, 2'b10 byte extend, 2'b11 halfword extend. In pack mode the bytes of `res_lo` come from these lanes: byte [7:0] from `src_lo[15:0]`, byte [15:8] from `src_lo[31:16]`, byte [23:16] from `src_hi[15:0]`, and byte [31:24] from `src_hi[31:16]`.
- R4: A pack lane whose signed value is above +127 produces byte 8'h7F.
- R5: A pack lane whose signed value is below -128 produces byte 8'h80.
- R6: A pack lane in the range -128..+127 produces its own low byte unchanged.
- R7: In pack mode, `sat_flags[k]` is 1 exactly when the lane feeding byte k of `res_lo` was clamped.
- R8: `sat_flags` is zero after any mode other than pack.
- R9: In unpack mode, `src_lo` bytes are sign-extended to 16 bits and placed as follows: byte [31:24] goes to `res_lo[31:16]`, byte [23:16] to `res_lo[15:0]`, byte [15:8] to `res_hi[31:16]`, and byte [7:0] to `res_hi[15:0]`.
- R10: In byte extend mode, `res_lo` is `src_lo[7:0]` sign-extended to 32 bits.
- R11: In halfword extend mode, `res_lo` is `src_lo[15:0]` sign-extended to 32 bits.
- R12: `res_hi` is zero after pack, byte extend and halfword extend.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 2 | Mode select (encoding in R3) |
| src_lo | input | 32 | Low register of the pair; the only source for unpack and extend |
| src_hi | input | 32 | High register of the pair, used by pack |
| res_lo | output | 32 | Packed word, extended scalar, or upper unpack half |
| res_hi | output | 32 | Lower unpack half; zero in the other modes |
| sat_flags | output | 4 | Per-byte saturation marks from pack |

## Verification
Pack is tried with four kinds of lanes. All-positive lanes that overflow tell the +127 clamp apart. All-negative lanes that underflow tell the -128 clamp apart. Lanes exactly at the limits +127 and -128 separate an off-by-one range test from a correct one. Small distinct lane values expose any swap in the lane order between the two registers. Random operands mix lanes that are sign-extended bytes with lanes that have arbitrary upper bits, so in-range and clamped lanes occur side by side. Unpack and both extend modes are driven with bytes and halfwords of both signs, which separates sign extension from zero extension and catches a wrong placement of the output halves.

// File: rtl/simd_pk_pkg.sv
package simd_pk_pkg;

    typedef enum logic [1:0] {
        OP_PACK   = 2'b00,
        OP_UNPACK = 2'b01,
        OP_EXT8   = 2'b10,
        OP_EXT16  = 2'b11
    } pk_op_e;

endpackage

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp #(
    parameter int IN_W  = 16,
    parameter int OUT_W = 8
) (
    input  logic [IN_W-1:0]  lane_i,
    output logic [OUT_W-1:0] byte_o,
    output logic             sat_o
);
    localparam int TOP_W = IN_W - OUT_W + 1;

    logic [TOP_W-1:0] top_bits;
    logic             neg;
    logic             fits;

    assign top_bits = lane_i[IN_W-1:OUT_W-1];
    assign neg      = lane_i[IN_W-1];
    // The lane fits when every bit from the target sign position upward agrees.
    assign fits     = (&top_bits) | ~(|top_bits);
    assign sat_o    = ~fits;

    always_comb begin
        if (fits) begin
            byte_o = lane_i[OUT_W-1:0];
        end else if (neg) begin
            byte_o = {1'b1, {(OUT_W-1){1'b0}}};
        end else begin
            byte_o = {1'b0, {(OUT_W-1){1'b1}}};
        end
    end
endmodule

// File: rtl/simd_sext.sv
module simd_sext #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 16
) (
    input  logic [IN_W-1:0]  val_i,
    output logic [OUT_W-1:0] val_o
);
    assign val_o = {{(OUT_W-IN_W){val_i[IN_W-1]}}, val_i};
endmodule

// File: rtl/simd_pack_unit.sv
module simd_pack_unit #(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 8
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [1:0]                         op_sel,
    input  logic [WORD_W-1:0]                  src_lo,
    input  logic [WORD_W-1:0]                  src_hi,
    output logic [WORD_W-1:0]                  res_lo,
    output logic [WORD_W-1:0]                  res_hi,
    output logic [WORD_W/NARROW_W-1:0]         sat_flags
);
    import simd_pk_pkg::*;

    localparam int WIDE_W = 2 * NARROW_W;
    localparam int LANES  = WORD_W / NARROW_W;

    pk_op_e                     op;
    logic [2*WORD_W-1:0]        pair_w;
    logic [WORD_W-1:0]          packed_w;
    logic [LANES-1:0]           sat_w;
    logic [LANES*WIDE_W-1:0]    wide_w;
    logic [WORD_W-1:0]          ext8_w;
    logic [WORD_W-1:0]          ext16_w;
    logic [WORD_W-1:0]          nxt_lo;
    logic [WORD_W-1:0]          nxt_hi;
    logic [LANES-1:0]           nxt_sat;

    assign op     = pk_op_e'(op_sel);
    assign pair_w = {src_hi, src_lo};

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        simd_lane_clamp #(
            .IN_W (WIDE_W),
            .OUT_W(NARROW_W)
        ) u_clamp (
            .lane_i(pair_w[k*WIDE_W +: WIDE_W]),
            .byte_o(packed_w[k*NARROW_W +: NARROW_W]),
            .sat_o (sat_w[k])
        );

        simd_sext #(
            .IN_W (NARROW_W),
            .OUT_W(WIDE_W)
        ) u_widen (
            .val_i(src_lo[k*NARROW_W +: NARROW_W]),
            .val_o(wide_w[k*WIDE_W +: WIDE_W])
        );
    end

    simd_sext #(
        .IN_W (NARROW_W),
        .OUT_W(WORD_W)
    ) u_ext8 (
        .val_i(src_lo[NARROW_W-1:0]),
        .val_o(ext8_w)
    );

    simd_sext #(
        .IN_W (WIDE_W),
        .OUT_W(WORD_W)
    ) u_ext16 (
        .val_i(src_lo[WIDE_W-1:0]),
        .val_o(ext16_w)
    );

    always_comb begin
        nxt_lo  = '0;
        nxt_hi  = '0;
        nxt_sat = '0;
        unique case (op)
            OP_PACK: begin
                nxt_lo  = packed_w;
                nxt_sat = sat_w;
            end
            OP_UNPACK: begin
                nxt_lo = wide_w[LANES*WIDE_W-1 -: WORD_W];
                nxt_hi = wide_w[WORD_W-1:0];
            end
            OP_EXT8:  nxt_lo = ext8_w;
            OP_EXT16: nxt_lo = ext16_w;
            default: begin
                nxt_lo  = '0;
                nxt_hi  = '0;
                nxt_sat = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_lo    <= '0;
            res_hi    <= '0;
            sat_flags <= '0;
        end else begin
            res_lo    <= nxt_lo;
            res_hi    <= nxt_hi;
            sat_flags <= nxt_sat;
        end
    end
endmodule

module simd_pack_unit_chk #(
    parameter int WORD_W   = 32,
    parameter int NARROW_W = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 op_sel,
    input logic [WORD_W-1:0]          src_lo,
    input logic [WORD_W-1:0]          res_lo,
    input logic [WORD_W-1:0]          res_hi,
    input logic [WORD_W/NARROW_W-1:0] sat_flags
);
    localparam int LANES  = WORD_W / NARROW_W;
    localparam int WIDE_W = 2 * NARROW_W;
    localparam logic [NARROW_W-1:0] POS_LIM = {1'b0, {(NARROW_W-1){1'b1}}};
    localparam logic [NARROW_W-1:0] NEG_LIM = {1'b1, {(NARROW_W-1){1'b0}}};

    for (genvar k = 0; k < LANES; k++) begin : g_sat
        // R7
        sat_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
            sat_flags[k] |-> (res_lo[k*NARROW_W +: NARROW_W] == POS_LIM
                           || res_lo[k*NARROW_W +: NARROW_W] == NEG_LIM));
    end

    // R8
    idle_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) != 2'b00) |-> (sat_flags == '0));

    // R12
    hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) != 2'b01) |-> (res_hi == '0));

    // R10
    ext8_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 2'b10)
        |-> (res_lo == {{(WORD_W-NARROW_W){$past(src_lo[NARROW_W-1])}},
                        $past(src_lo[NARROW_W-1:0])}));

    // R11
    ext16_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 2'b11)
        |-> (res_lo[WORD_W-1:WIDE_W-1] == {(WORD_W-WIDE_W+1){$past(src_lo[WIDE_W-1])}}));

    // R9
    unpack_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(op_sel) == 2'b01)
        |-> (res_lo[WORD_W-1 -: WIDE_W] ==
             {{NARROW_W{$past(src_lo[WORD_W-1])}}, $past(src_lo[WORD_W-1 -: NARROW_W])}));

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_zero_chk: assert (res_lo == '0 && res_hi == '0 && sat_flags == '0);
        end
    end
endmodule

bind simd_pack_unit simd_pack_unit_chk #(
    .WORD_W  (WORD_W),
    .NARROW_W(NARROW_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_sel   (op_sel),
    .src_lo   (src_lo),
    .res_lo   (res_lo),
    .res_hi   (res_hi),
    .sat_flags(sat_flags)
);

// File: tb/simd_pack_unit_tb.sv
module simd_pack_unit_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  op_sel = 2'b00;
    logic [31:0] src_lo = 32'h0;
    logic [31:0] src_hi = 32'h0;
    logic [31:0] res_lo;
    logic [31:0] res_hi;
    logic [3:0]  sat_flags;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    simd_pack_unit dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_sel   (op_sel),
        .src_lo   (src_lo),
        .src_hi   (src_hi),
        .res_lo   (res_lo),
        .res_hi   (res_hi),
        .sat_flags(sat_flags)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_clamp(input logic [15:0] x, output bit sat);
        int v;
        v = int'($signed(x));
        sat = 1'b1;
        if (v > 127) return 8'h7F;
        if (v < -128) return 8'h80;
        sat = 1'b0;
        return x[7:0];
    endfunction

    function automatic logic [15:0] ref_wide(input logic [7:0] b);
        int v;
        v = int'($signed(b));
        return 16'(v);
    endfunction

    task automatic ref_model(input logic [1:0] op, input logic [31:0] lo, input logic [31:0] hi,
                             output logic [31:0] e_lo, output logic [31:0] e_hi,
                             output logic [3:0] e_sat);
        logic [15:0] lanes [4];
        bit s;
        e_lo = 32'h0;
        e_hi = 32'h0;
        e_sat = 4'h0;
        lanes[0] = lo[15:0];
        lanes[1] = lo[31:16];
        lanes[2] = hi[15:0];
        lanes[3] = hi[31:16];
        case (op)
            2'b00: begin
                for (int k = 0; k < 4; k++) begin
                    e_lo[k*8 +: 8] = ref_clamp(lanes[k], s);
                    e_sat[k] = s;
                end
            end
            2'b01: begin
                e_lo = {ref_wide(lo[31:24]), ref_wide(lo[23:16])};
                e_hi = {ref_wide(lo[15:8]), ref_wide(lo[7:0])};
            end
            2'b10: e_lo = 32'(int'($signed(lo[7:0])));
            default: e_lo = 32'(int'($signed(lo[15:0])));
        endcase
    endtask

    task automatic do_op(input logic [1:0] op, input logic [31:0] lo, input logic [31:0] hi,
                         input string tag);
        logic [31:0] p_lo, e_lo, e_hi;
        logic [3:0] e_sat;
        @(negedge clk);
        p_lo = res_lo;
        op_sel = op;
        src_lo = lo;
        src_hi = hi;
        ref_model(op, lo, hi, e_lo, e_hi, e_sat);
        #1;
        check("R2", "held before edge", res_lo, p_lo);
        @(negedge clk);
        check(tag, "res_lo", res_lo, e_lo);
        check(op == 2'b01 ? tag : "R12", "res_hi", res_hi, e_hi);
        check(op == 2'b00 ? "R7" : "R8", "sat_flags", {28'h0, sat_flags}, {28'h0, e_sat});
    endtask

    function automatic logic [15:0] rnd_lane();
        logic [31:0] r;
        r = $urandom;
        if (r[31]) return {{8{r[7]}}, r[7:0]};
        return r[15:0];
    endfunction

    initial begin
        void'($urandom(32'd20240611));
        src_lo = 32'hDEAD_BEEF;
        src_hi = 32'h8000_7FFF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "reset res_lo", res_lo, 32'h0);
        check("R1", "reset res_hi", res_hi, 32'h0);
        check("R1", "reset flags", {28'h0, sat_flags}, 32'h0);
        rst_n = 1'b1;

        // R3 lane order
        do_op(2'b00, 32'h0002_0001, 32'h0004_0003, "R3");
        check("R3", "literal order", res_lo, 32'h0403_0201);
        // R4 positive saturation
        do_op(2'b00, 32'h0080_7FFF, 32'h0100_0200, "R4");
        check("R4", "all +127", res_lo, 32'h7F7F_7F7F);
        check("R7", "all flagged", {28'h0, sat_flags}, 32'hF);
        // R5 negative saturation
        do_op(2'b00, 32'h8000_FF7F, 32'hFF00_FE00, "R5");
        check("R5", "all -128", res_lo, 32'h8080_8080);
        // R6 boundary values pass through
        do_op(2'b00, 32'hFF80_007F, 32'hFFFF_0000, "R6");
        check("R6", "limits kept", res_lo, 32'hFF00_807F);
        check("R7", "no flags", {28'h0, sat_flags}, 32'h0);
        // R7 mixed lanes
        do_op(2'b00, 32'h0005_0080, 32'hFF7F_0010, "R7");
        check("R7", "mixed flags", {28'h0, sat_flags}, 32'h9);
        // R9 unpack
        do_op(2'b01, 32'h807F_01FE, 32'hFFFF_FFFF, "R9");
        check("R9", "unpack lo", res_lo, 32'hFF80_007F);
        check("R9", "unpack hi", res_hi, 32'h0001_FFFE);
        // R8 flags clear after saturating pack
        do_op(2'b00, 32'h7FFF_7FFF, 32'h7FFF_7FFF, "R4");
        do_op(2'b01, 32'h0000_0000, 32'h7FFF_7FFF, "R8");
        // R10 / R11 scalar extends
        do_op(2'b10, 32'h1234_5680, 32'h0, "R10");
        check("R10", "byte ext neg", res_lo, 32'hFFFF_FF80);
        do_op(2'b10, 32'hFFFF_FF7F, 32'h0, "R10");
        check("R10", "byte ext pos", res_lo, 32'h0000_007F);
        do_op(2'b11, 32'h0000_8001, 32'h1, "R11");
        check("R11", "half ext neg", res_lo, 32'hFFFF_8001);
        do_op(2'b11, 32'h1234_7FFF, 32'h1, "R11");
        check("R11", "half ext pos", res_lo, 32'h0000_7FFF);

        for (int i = 0; i < 400; i++) begin
            logic [1:0] op;
            string tag;
            op = 2'($urandom_range(0, 3));
            case (op)
                2'b00: tag = "R3";
                2'b01: tag = "R9";
                2'b10: tag = "R10";
                default: tag = "R11";
            endcase
            do_op(op, {rnd_lane(), rnd_lane()}, {rnd_lane(), rnd_lane()}, tag);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule